// File: doc/BRIEF.md
# Digit-Serial Gaussian Normal Basis Multiplier

This block multiplies two elements of GF(2^m) that are given in a type-t Gaussian normal basis, with p = m*t + 1 prime. After a start pulse, each m-bit operand is expanded into a p-bit redundant vector. In that vector, position k (for k = 1..p-1) holds the normal-basis coordinate i that satisfies k = 2^i * u^j mod p. Here u is an element of multiplicative order t modulo p, and position 0 is zero. In this form, multiplying by the field generator gamma is a cyclic rotation. Reducing modulo gamma^p + 1 is a fold of the upper bits onto the lower ones.

The second operand is consumed one d-bit digit per round, least significant digit first. A round builds the partial product of the first operand with the current digit, one d-bit output segment per cycle. Each segment is a small Hankel matrix-vector product. The round then folds the wide partial product to p bits, XORs it into an accumulator and rotates the first operand by d positions. After n = ceil(p/d) rounds, the accumulator is mapped back to m normal-basis bits. Coordinate i is accumulator position 2^i mod p XOR accumulator position 0, which removes the constant term. The result is held on `product`.

The interface is plain control, not a stream: the operands must stay stable from the accepted start until done. `busy` low means a start will be accepted. There is no back-pressure, because the result register simply holds its value until the next accepted start.

Top module: `gnb_digit_mult`

## Requirements
- R1: `product` equals the GF(2^m) product of `a_in` and `b_in` in the type-T Gaussian normal basis. Bit i is the coefficient of the i-th conjugate alpha^(2^i) of the normal element.
- R2: With a start accepted at clock edge E, `done` is high in exactly the cycle after edge E + D + N*(N+1), where N = ceil((M*T+1)/D).
- R3: `done` lasts one cycle, `busy` is high in every cycle from the accepted start up to the done cycle, and `busy` and `done` are never high together.
- R4: A start pulse while `busy` is high is ignored: it neither restarts nor delays the running product, and the result is unchanged.
- R5: After reset, `busy` and `done` are low and `product` is zero.
- R6: `product` keeps its value after done until the next accepted start, even when `a_in` and `b_in` change while the block is idle.
- R7: Multiplying by the all-zero vector gives zero. Multiplying by the all-ones vector, which is the field unit, returns the other operand.
- R8: Squaring an element gives its coordinates rotated up by one: bit i+1 of the result is bit i of the operand, and bit 0 is bit M-1.
- R9: The result does not depend on the digit size D: two instances that differ only in D produce the same product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, accepted when `busy` is low |
| a_in | input | M | First operand, normal-basis coordinates |
| b_in | input | M | Second operand, normal-basis coordinates |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse when `product` is updated |
| product | output | M | Product in normal-basis coordinates |

## Verification
Four instances run side by side: type-1 with p = 5 and type-2 with p = 11, each at d = 2 and d = 3. For type-1, the position-0 correction matters. If it were dropped, most products would come out with every bit inverted in the wrong cases, and the reference comparison would flag them. The digit counts do not divide p evenly, so a design that mishandles the zero padding or the rotation wrap-around would give products that differ between the two digit sizes. Squaring, the zero and unit operands, a start pulse issued in mid-run, and operand changes while idle are all aimed at control logic. A design that restarted on that pulse would show a late done, and one that sampled the operands after done would show a changed product.

// File: rtl/gnb_pkg.sv
package gnb_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FILL,
    S_RUN,
    S_DONE
  } gnb_state_e;

  // b^e mod p for small constant arguments
  function automatic int pow_mod(input int b, input int e, input int p);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = (r * b) % p;
    return r;
  endfunction

  // multiplicative order of u modulo p
  function automatic int order_mod(input int u, input int p);
    int r;
    r = u % p;
    for (int k = 1; k < p; k++) begin
      if (r == 1) return k;
      r = (r * u) % p;
    end
    return p;
  endfunction

  // smallest residue whose order is exactly t
  function automatic int unit_of_order(input int t, input int p);
    for (int c = 1; c < p; c++)
      if (order_mod(c, p) == t) return c;
    return 1;
  endfunction

  // normal-basis coordinate that owns redundant position k
  function automatic int class_of(input int k, input int m, input int t, input int p);
    int u;
    u = unit_of_order(t, p);
    for (int i = 0; i < m; i++)
      for (int j = 0; j < t; j++)
        if ((pow_mod(2, i, p) * pow_mod(u, j, p)) % p == k) return i;
    return 0;
  endfunction

endpackage

// File: rtl/gnb_expand.sv
module gnb_expand #(
  parameter int M = 4,
  parameter int T = 1
) (
  input  logic [M-1:0]   nb,
  output logic [M*T:0]   ex
);
  import gnb_pkg::*;
  localparam int P = M * T + 1;

  assign ex[0] = 1'b0;

  for (genvar k = 1; k < P; k++) begin : g_pos
    localparam int CLS = class_of(k, M, T, P);
    assign ex[k] = nb[CLS];
  end
endmodule

// File: rtl/gnb_hankel_seg.sv
module gnb_hankel_seg #(
  parameter int D = 2
) (
  input  logic [2*D-2:0] win,
  input  logic [D-1:0]   digit,
  output logic [D-1:0]   seg
);
  // seg[j] = XOR over l of digit[l] & a[base + j - l]; win[e] holds a[base - D + 1 + e]
  always_comb begin
    for (int j = 0; j < D; j++) begin
      logic s;
      s = 1'b0;
      for (int l = 0; l < D; l++) s = s ^ (digit[l] & win[j - l + D - 1]);
      seg[j] = s;
    end
  end
endmodule

// File: rtl/gnb_fold.sv
module gnb_fold #(
  parameter int XW = 8,
  parameter int P  = 5
) (
  input  logic [XW-1:0] wide,
  output logic [P-1:0]  folded
);
  always_comb begin
    folded = '0;
    for (int w = 0; w < XW; w++) folded[w % P] = folded[w % P] ^ wide[w];
  end
endmodule

// File: rtl/gnb_digit_mult.sv
module gnb_digit_mult #(
  parameter int M = 4,
  parameter int T = 1,
  parameter int D = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] a_in,
  input  logic [M-1:0] b_in,
  output logic         busy,
  output logic         done,
  output logic [M-1:0] product
);
  import gnb_pkg::*;

  localparam int P    = M * T + 1;
  localparam int N    = (P + D - 1) / D;
  localparam int XW   = (N + 1) * D;
  localparam int EW   = (N + 2) * D - 1;
  localparam int CMAX = (D > N + 1) ? D : N + 1;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int DW   = $clog2(N + 1);
  localparam int LAT  = D + N * (N + 1);

  gnb_state_e      state;
  logic [CW-1:0]   cnt;
  logic [DW-1:0]   dig;
  logic [P-1:0]    a_ex, b_ex, a_rot, a_rot_next, b_hold, acc, acc_next, folded;
  logic [XW-1:0]   xreg, xnext;
  logic [EW-1:0]   ext;
  logic [N*D-1:0]  bpad;
  logic [2*D-2:0]  win;
  logic [D-1:0]    digit, seg;
  logic [M-1:0]    prod_q, prod_next;
  logic            accept, last_seg;

  gnb_expand #(.M(M), .T(T)) u_exp_a (.nb(a_in), .ex(a_ex));
  gnb_expand #(.M(M), .T(T)) u_exp_b (.nb(b_in), .ex(b_ex));

  assign accept   = start && (state == S_IDLE || state == S_DONE);
  assign last_seg = (state == S_RUN) && (cnt == CW'(N));

  // operand windows for the current segment and digit
  always_comb begin
    ext = '0;
    ext[D-1 +: P] = a_rot;
    bpad = '0;
    bpad[P-1:0] = b_hold;
    win   = ext[cnt * D +: 2 * D - 1];
    digit = bpad[dig * D +: D];
  end

  gnb_hankel_seg #(.D(D)) u_seg (.win(win), .digit(digit), .seg(seg));

  always_comb begin
    xnext = xreg;
    xnext[cnt * D +: D] = seg;
  end

  gnb_fold #(.XW(XW), .P(P)) u_fold (.wide(xnext), .folded(folded));

  assign acc_next = acc ^ folded;

  // multiply by gamma^D: cyclic rotation of the p-bit vector
  for (genvar k = 0; k < P; k++) begin : g_rot
    assign a_rot_next[(k + D) % P] = a_rot[k];
  end

  // back to normal basis, removing the constant term at position 0
  for (genvar i = 0; i < M; i++) begin : g_cmp
    localparam int POS = pow_mod(2, i, P);
    assign prod_next[i] = acc_next[POS] ^ acc_next[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      dig    <= '0;
      a_rot  <= '0;
      b_hold <= '0;
      acc    <= '0;
      xreg   <= '0;
      prod_q <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: begin
          if (accept) begin
            a_rot  <= a_ex;
            b_hold <= b_ex;
            acc    <= '0;
            cnt    <= '0;
            dig    <= '0;
            state  <= S_FILL;
          end else begin
            state <= S_IDLE;
          end
        end
        S_FILL: begin
          if (cnt == CW'(D - 1)) begin
            cnt   <= '0;
            state <= S_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RUN: begin
          xreg <= xnext;
          if (last_seg) begin
            acc   <= acc_next;
            a_rot <= a_rot_next;
            cnt   <= '0;
            if (dig == DW'(N - 1)) begin
              state  <= S_DONE;
              prod_q <= prod_next;
            end else begin
              dig <= dig + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy    = (state == S_FILL) || (state == S_RUN);
  assign done    = (state == S_DONE);
  assign product = prod_q;

  // ---------------- assertions ----------------
  logic [31:0] watch;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              watch <= '0;
    else if (start && !busy) watch <= '0;
    else if (busy)           watch <= watch + 1;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (watch == 32'(LAT)));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

  // every redundant position agrees with the coordinate that owns it (R1)
  for (genvar k = 1; k < P; k++) begin : g_chk
    localparam int CLS = class_of(k, M, T, P);
    p_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((acc[k] ^ acc[0]) == product[CLS]));
  end

endmodule

// File: tb/test_gnb_digit_mult.sv
module test_gnb_digit_mult;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] a_in = '0;
  logic [4:0] b_in = '0;

  always #2.5 clk = ~clk;

  logic [3:0] busy_v, done_v;
  logic [3:0] p1, p2;
  logic [4:0] p3, p4;
  int checks = 0;
  int failures = 0;

  // u1: m4 t1 d2, u2: m4 t1 d3, u3: m5 t2 d3, u4: m5 t2 d2
  gnb_digit_mult #(.M(4), .T(1), .D(2)) i_gnb_digit_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in[3:0]), .b_in(b_in[3:0]),
    .busy(busy_v[0]), .done(done_v[0]), .product(p1));
  gnb_digit_mult #(.M(4), .T(1), .D(3)) i_gnb_digit_mult_b (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in[3:0]), .b_in(b_in[3:0]),
    .busy(busy_v[1]), .done(done_v[1]), .product(p2));
  gnb_digit_mult #(.M(5), .T(2), .D(3)) i_gnb_digit_mult_c (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .busy(busy_v[2]), .done(done_v[2]), .product(p3));
  gnb_digit_mult #(.M(5), .T(2), .D(2)) i_gnb_digit_mult_d (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .busy(busy_v[3]), .done(done_v[3]), .product(p4));

  localparam int LAT [4] = '{14, 9, 23, 44};

  localparam logic [9:0] VEC [8] = '{
    {5'h13, 5'h06}, {5'h0B, 5'h19}, {5'h1F, 5'h1F}, {5'h01, 5'h10},
    {5'h15, 5'h0A}, {5'h07, 5'h1C}, {5'h10, 5'h10}, {5'h0E, 5'h03}};

  function automatic logic [4:0] prod_of(input int u);
    case (u)
      0: return {1'b0, p1};
      1: return {1'b0, p2};
      2: return p3;
      default: return p4;
    endcase
  endfunction

  // independent model: expand, cyclic convolution mod p, compress
  function automatic logic [4:0] ref_mul(input int m, input int t, input logic [4:0] a,
                                         input logic [4:0] b);
    int p, u, r, ord, p2, uj, k;
    int fx [16];
    logic ax [16];
    logic bx [16];
    logic cx [16];
    logic [4:0] res;
    p = m * t + 1;
    u = 1;
    for (int c = 1; c < p; c++) begin
      r = c; ord = 1;
      for (int s = 0; s < p && r != 1; s++) begin r = (r * c) % p; ord++; end
      if (ord == t) begin u = c; break; end
    end
    for (int x = 0; x < 16; x++) begin fx[x] = 0; ax[x] = 0; bx[x] = 0; cx[x] = 0; end
    p2 = 1;
    for (int i = 0; i < m; i++) begin
      uj = 1;
      for (int j = 0; j < t; j++) begin
        k = (p2 * uj) % p;
        fx[k] = i;
        uj = (uj * u) % p;
      end
      p2 = (p2 * 2) % p;
    end
    for (int x = 1; x < p; x++) begin ax[x] = a[fx[x]]; bx[x] = b[fx[x]]; end
    for (int x = 0; x < p; x++)
      for (int y = 0; y < p; y++)
        cx[(x + y) % p] = cx[(x + y) % p] ^ (ax[x] & bx[y]);
    res = '0;
    p2 = 1;
    for (int i = 0; i < m; i++) begin
      res[i] = cx[p2] ^ cx[0];
      p2 = (p2 * 2) % p;
    end
    return res;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [4:0] a, input logic [4:0] b, input logic [4:0] e4,
                         input logic [4:0] e5, input int glitch_at, input string tag);
    logic [4:0] ex [4];
    bit seen [4];
    ex[0] = e4; ex[1] = e4; ex[2] = e5; ex[3] = e5;
    for (int u = 0; u < 4; u++) seen[u] = 0;
    @(negedge clk);
    a_in = a; b_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy_v == 4'hF, "R3 busy after start", busy_v, 4'hF);
    for (int c = 1; c <= 60; c++) begin
      start = (c == glitch_at);
      @(negedge clk);
      for (int u = 0; u < 4; u++) begin
        if (done_v[u]) begin
          seen[u] = 1;
          chk(c == LAT[u], glitch_at > 0 ? "R4 latency with mid-run start" : "R2 done cycle",
              c, LAT[u]);
          chk(prod_of(u) == ex[u], tag, prod_of(u), ex[u]);
          chk(!busy_v[u], "R3 busy low at done", busy_v[u], 0);
        end
        if (c == LAT[u] + 1) chk(!done_v[u], "R3 done single cycle", done_v[u], 0);
      end
    end
    start = 1'b0;
    for (int u = 0; u < 4; u++) begin
      chk(seen[u], "R2 done seen", seen[u], 1);
      chk(prod_of(u) == ex[u], "R6 product held", prod_of(u), ex[u]);
    end
    chk(p1 == p2, "R9 same product for d=2 and d=3 (m=4)", p1, p2);
    chk(p3 == p4, "R9 same product for d=2 and d=3 (m=5)", p3, p4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R2 actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    chk(busy_v == 4'h0, "R5 busy in reset", busy_v, 0);
    chk(done_v == 4'h0, "R5 done in reset", done_v, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(p1 == 4'h0 && p3 == 5'h0, "R5 product after reset", {p1, p3}, 0);
    chk(busy_v == 4'h0 && done_v == 4'h0, "R5 idle after reset", {busy_v, done_v}, 0);

    // R1: vector table against the reference model
    for (int v = 0; v < 8; v++) begin
      logic [4:0] a, b;
      a = VEC[v][9:5];
      b = VEC[v][4:0];
      run_vec(a, b, ref_mul(4, 1, {1'b0, a[3:0]}, {1'b0, b[3:0]}), ref_mul(5, 2, a, b), 0,
              "R1 product vs reference");
    end

    // R7: zero and unit operands
    run_vec(5'h16, 5'h00, 5'h00, 5'h00, 0, "R7 times zero");
    run_vec(5'h16, 5'h1F, 5'h06, 5'h16, 0, "R7 times unit");
    run_vec(5'h1F, 5'h0D, 5'h0D, 5'h0D, 0, "R7 unit times b");

    // R8: squaring rotates coordinates up by one
    run_vec(5'h0B, 5'h0B, {1'b0, 3'b011, 1'b1}, {4'b1011, 1'b0}, 0, "R8 square");
    run_vec(5'h12, 5'h12, {1'b0, 3'b010, 1'b0}, {4'b0010, 1'b1}, 0, "R8 square wrap");

    // R4: start pulse in the middle of a run is ignored
    run_vec(5'h13, 5'h06, ref_mul(4, 1, 5'h03, 5'h06), ref_mul(5, 2, 5'h13, 5'h06), 2,
            "R4 product with mid-run start");

    // R6: operand changes while idle do not touch the held product
    begin
      logic [3:0] h1;
      logic [4:0] h3;
      h1 = p1; h3 = p3;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        a_in = 5'(c * 7 + 3);
        b_in = 5'(c * 5 + 1);
      end
      @(negedge clk);
      chk(p1 == h1, "R6 m4 product after idle operand change", p1, h1);
      chk(p3 == h3, "R6 m5 product after idle operand change", p3, h3);
      chk(busy_v == 4'h0 && done_v == 4'h0, "R6 no run without start", {busy_v, done_v}, 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule